// File: doc/BRIEF.md
# Two-Step Vector Reduction Unit

This block reduces one vector of 32 lanes, each 32 bits wide, using a selectable integer operator. It works in two steps chosen per vector. In the chunk step it splits the vector into four groups of eight neighbouring lanes. Each group is reduced on its own, and the result replaces the group's lowest lane, so lanes 0, 8, 16 and 24 carry the four partial values. In the final step it folds those four lanes together and writes the total into lane 0.

Every lane that the selected step does not write leaves the unit with its input value. A reduction is therefore two passes through the unit: one chunk pass, then one final pass on the vector that the chunk pass produced. The unit is fully pipelined. It accepts one vector per clock and returns results two clocks later, in the order the vectors arrived.

Top module: `vred_top`

## Requirements
- R1: Lane i of `inData` and of `outData` occupies bits [32*i+31 : 32*i], for i from 0 to 31.
- R2: When `inMode` is 0 (chunk step), output lane 8k for k = 0..3 equals the selected operator applied to input lanes 8k through 8k+7.
- R3: When `inMode` is 0, every output lane whose index is not a multiple of 8 equals the same input lane.
- R4: When `inMode` is 1 (final step), output lane 0 equals the selected operator applied to input lanes 0, 8, 16 and 24, and no other input lane affects it.
- R5: When `inMode` is 1, output lanes 1 to 31 equal the same input lanes.
- R6: `inOp` selects the operator: 0 wrapping add modulo 2^32, 1 signed minimum, 2 signed maximum, 3 unsigned minimum, 4 unsigned maximum, 5 bitwise AND, 6 bitwise OR, 7 bitwise XOR.
- R7: A vector presented with `inVld` high at one rising edge produces `outVld` high, with its result on `outData`, after exactly the second rising edge from that one. `outVld` stays low after the first.
- R8: Vectors presented on consecutive clocks return on consecutive clocks in arrival order, each with its own mode and operator.
- R9: While `rstN` is low and after it is released with no input, `outVld` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Active-low synchronous reset |
| inVld | input | 1 | Input vector is valid this cycle |
| inMode | input | 1 | 0 = chunk step, 1 = final step |
| inOp | input | 3 | Operator code (see R6) |
| inData | input | 1024 | 32 lanes of 32 bits, lane 0 in the low bits |
| outVld | output | 1 | Result vector is valid this cycle |
| outData | output | 1024 | Result vector, same lane layout |

## Verification
Lane data mixes values with the top bit set and values with it clear. The signed and unsigned variants of min and max then pick different winners, so a design that swapped them, or mixed up the operator codes, returns the wrong head lanes. An add case on all-ones lanes checks that a design wrapping at the wrong width, or saturating, gives a value other than 0xFFFFFFF8. Final-step cases put noise in the non-head lanes, which catches a design that folds the whole vector or writes lanes other than 0. Back-to-back vectors with different modes catch a design whose operator or mode control lags its data by a stage, or whose valid flag arrives a cycle early or late.

// File: rtl/vred_pkg.sv
package vred_pkg;
  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_SMIN = 3'd1,
    OP_SMAX = 3'd2,
    OP_UMIN = 3'd3,
    OP_UMAX = 3'd4,
    OP_AND  = 3'd5,
    OP_OR   = 3'd6,
    OP_XOR  = 3'd7
  } redOp_e;

  typedef enum logic {
    MODE_CHUNK = 1'b0,
    MODE_FINAL = 1'b1
  } redMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic     s1Load;  // capture input vector into stage 1
    logic     s2Load;  // capture reduced vector into output stage
    redOp_e   op;      // operator of the vector held in stage 1
    redMode_e mode;    // step of the vector held in stage 1
  } redStrobe_t;
endpackage

// File: rtl/vred_ctrl.sv
module vred_ctrl
  import vred_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inVld,
  input  logic       inMode,
  input  logic [2:0] inOp,
  output redStrobe_t strb,
  output logic       outVld
);
  logic     s1Vld, s2Vld;
  redOp_e   s1Op;
  redMode_e s1Mode;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      s1Vld  <= 1'b0;
      s2Vld  <= 1'b0;
      s1Op   <= OP_ADD;
      s1Mode <= MODE_CHUNK;
    end else begin
      s1Vld <= inVld;
      s2Vld <= s1Vld;
      if (inVld) begin
        s1Op   <= redOp_e'(inOp);
        s1Mode <= redMode_e'(inMode);
      end
    end
  end

  always_comb begin
    strb.s1Load = inVld;
    strb.s2Load = s1Vld;
    strb.op     = s1Op;
    strb.mode   = s1Mode;
  end

  assign outVld = s2Vld;

  // R7: accepted input shows up as a valid output two edges later
  p_valid_latency_r7: assert property (@(posedge clk) disable iff (!rstN)
    inVld |=> ##1 outVld);
  // R8: no output without a matching input two edges earlier
  p_no_spurious_r8: assert property (@(posedge clk) disable iff (!rstN)
    !inVld |=> ##1 !outVld);
  // R7: one edge is not enough
  p_not_early_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!inVld && !strb.s2Load) |=> !outVld);
endmodule

// File: rtl/vred_datapath.sv
module vred_datapath
  import vred_pkg::*;
#(
  parameter int LANES = 32,
  parameter int WIDTH = 32,
  parameter int CHUNK = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  redStrobe_t             strb,
  input  logic [LANES*WIDTH-1:0] inData,
  output logic [LANES*WIDTH-1:0] outData
);
  localparam int NCH    = LANES / CHUNK;
  localparam int CNODES = 2 * CHUNK - 1;
  localparam int FNODES = 2 * NCH - 1;

  function automatic logic [WIDTH-1:0] combine(redOp_e op, logic [WIDTH-1:0] a,
                                               logic [WIDTH-1:0] b);
    unique case (op)
      OP_ADD:  return a + b;
      OP_SMIN: return ($signed(a) < $signed(b)) ? a : b;
      OP_SMAX: return ($signed(a) > $signed(b)) ? a : b;
      OP_UMIN: return (a < b) ? a : b;
      OP_UMAX: return (a > b) ? a : b;
      OP_AND:  return a & b;
      OP_OR:   return a | b;
      default: return a ^ b;
    endcase
  endfunction

  logic [LANES*WIDTH-1:0] s1Data;
  logic [LANES*WIDTH-1:0] nextData;
  logic [WIDTH-1:0]       chunkRes [NCH];
  logic [WIDTH-1:0]       finNode  [FNODES];

  always_ff @(posedge clk) begin
    if (strb.s1Load) s1Data <= inData;
    if (strb.s2Load) outData <= nextData;
  end

  // one heap-ordered tree per chunk: leaves at CHUNK-1 .. 2*CHUNK-2
  for (genvar c = 0; c < NCH; c++) begin : g_chunk
    logic [WIDTH-1:0] node [CNODES];
    for (genvar j = 0; j < CHUNK; j++) begin : g_leaf
      assign node[CHUNK-1+j] = s1Data[(c*CHUNK+j)*WIDTH +: WIDTH];
    end
    for (genvar n = 0; n < CHUNK - 1; n++) begin : g_node
      assign node[n] = combine(strb.op, node[2*n+1], node[2*n+2]);
    end
    assign chunkRes[c] = node[0];
  end

  // final tree over chunk head lanes
  for (genvar j = 0; j < NCH; j++) begin : g_fleaf
    assign finNode[NCH-1+j] = s1Data[(j*CHUNK)*WIDTH +: WIDTH];
  end
  for (genvar n = 0; n < NCH - 1; n++) begin : g_fnode
    assign finNode[n] = combine(strb.op, finNode[2*n+1], finNode[2*n+2]);
  end

  always_comb begin
    nextData = s1Data;
    if (strb.mode == MODE_CHUNK) begin
      for (int c = 0; c < NCH; c++)
        nextData[(c*CHUNK)*WIDTH +: WIDTH] = chunkRes[c];
    end else begin
      nextData[0 +: WIDTH] = finNode[0];
    end
  end

  // R3: a non-head lane survives the chunk step untouched
  p_keep_lane_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.s2Load && strb.mode == MODE_CHUNK) |=>
      outData[WIDTH +: WIDTH] == $past(s1Data[WIDTH +: WIDTH]));
  // R5: a chunk head other than lane 0 survives the final step
  p_keep_head_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.s2Load && strb.mode == MODE_FINAL) |=>
      outData[CHUNK*WIDTH +: WIDTH] == $past(s1Data[CHUNK*WIDTH +: WIDTH]));
  // R6: unsigned minimum never exceeds the lane it started from
  p_umin_bound_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.s2Load && strb.op == OP_UMIN) |=>
      outData[0 +: WIDTH] <= $past(s1Data[0 +: WIDTH]));
  // R6: AND result has no bit outside the head lane
  p_and_subset_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.s2Load && strb.op == OP_AND) |=>
      (outData[0 +: WIDTH] & ~$past(s1Data[0 +: WIDTH])) == '0);
endmodule

// File: rtl/vred_top.sv
module vred_top
  import vred_pkg::*;
#(
  parameter int LANES = 32,
  parameter int WIDTH = 32,
  parameter int CHUNK = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   inVld,
  input  logic                   inMode,
  input  logic [2:0]             inOp,
  input  logic [LANES*WIDTH-1:0] inData,
  output logic                   outVld,
  output logic [LANES*WIDTH-1:0] outData
);
  redStrobe_t strb;

  vred_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .inVld  (inVld),
    .inMode (inMode),
    .inOp   (inOp),
    .strb   (strb),
    .outVld (outVld)
  );

  vred_datapath #(
    .LANES (LANES),
    .WIDTH (WIDTH),
    .CHUNK (CHUNK)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .inData  (inData),
    .outData (outData)
  );

  // R9: nothing valid leaves the unit in the cycle after reset
  p_reset_quiet_r9: assert property (@(posedge clk) !rstN |=> !outVld);
endmodule

// File: tb/sim_vred_top.sv
module sim_vred_top;
  localparam int CLK_PERIOD = 10;
  localparam int NL = 32;
  localparam int W  = 32;
  localparam int VW = NL * W;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          inVld = 1'b0;
  logic          inMode = 1'b0;
  logic [2:0]    inOp = 3'd0;
  logic [VW-1:0] inData = '0;
  logic          outVld;
  logic [VW-1:0] outData;

  int nChecks = 0;
  int nFails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vred_top u0 (
    .clk(clk), .rstN(rstN), .inVld(inVld), .inMode(inMode), .inOp(inOp),
    .inData(inData), .outVld(outVld), .outData(outData)
  );

  function automatic logic [W-1:0] opRef(int op, logic [W-1:0] a, logic [W-1:0] b);
    case (op)
      0: return a + b;
      1: return ($signed(a) <= $signed(b)) ? a : b;
      2: return ($signed(a) >= $signed(b)) ? a : b;
      3: return (a <= b) ? a : b;
      4: return (a >= b) ? a : b;
      5: return a & b;
      6: return a | b;
      default: return a ^ b;
    endcase
  endfunction

  function automatic logic [VW-1:0] refVec(logic mode, int op, logic [VW-1:0] v);
    logic [VW-1:0] r = v;
    logic [W-1:0] acc;
    if (!mode) begin
      for (int c = 0; c < 4; c++) begin
        acc = v[(c*8)*W +: W];
        for (int j = 1; j < 8; j++) acc = opRef(op, acc, v[(c*8+j)*W +: W]);
        r[(c*8)*W +: W] = acc;
      end
    end else begin
      acc = v[0 +: W];
      for (int c = 1; c < 4; c++) acc = opRef(op, acc, v[(c*8)*W +: W]);
      r[0 +: W] = acc;
    end
    return r;
  endfunction

  function automatic logic [VW-1:0] makeVec(int seed);
    logic [VW-1:0] v;
    for (int i = 0; i < NL; i++) begin
      v[i*W +: W] = (i * 32'h9E3779B9) ^ (seed * 32'h85EBCA6B) ^ ((i % 3 == 0) ? 32'h8000_0000 : 32'h0);
    end
    return v;
  endfunction

  task automatic checkBit(string req, logic act, logic exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: outVld actual %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic checkVec(string req, logic [VW-1:0] act, logic [VW-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      for (int i = 0; i < NL; i++) begin
        if (act[i*W +: W] !== exp[i*W +: W]) begin
          $display("FAIL %s: lane %0d actual %h expected %h", req, i, act[i*W +: W], exp[i*W +: W]);
          break;
        end
      end
    end
  endtask

  // one vector through the pipe, with its exact timing checked
  task automatic runOne(string req, logic mode, int op, logic [VW-1:0] v);
    inVld = 1'b1; inMode = mode; inOp = 3'(op); inData = v;
    @(negedge clk);
    inVld = 1'b0; inData = '0;
    checkBit({req, "/R7 early"}, outVld, 1'b0);
    @(negedge clk);
    checkBit({req, "/R7 valid"}, outVld, 1'b1);
    checkVec(req, outData, refVec(mode, op, v));
    @(negedge clk);
    checkBit({req, "/R7 single pulse"}, outVld, 1'b0);
  endtask

  task automatic tReset();
    checkBit("R9 in reset", outVld, 1'b0);
    @(negedge clk); @(negedge clk);
    rstN = 1'b1;
    @(negedge clk); @(negedge clk);
    checkBit("R9 after reset", outVld, 1'b0);
  endtask

  task automatic tChunkOps();
    for (int op = 0; op < 8; op++) runOne("R2 R3 R6 chunk", 1'b0, op, makeVec(op + 1));
  endtask

  task automatic tFinalOps();
    for (int op = 0; op < 8; op++) runOne("R4 R5 R6 final", 1'b1, op, makeVec(op + 20));
  endtask

  task automatic tAddWrap();
    logic [VW-1:0] v = '1;
    logic [VW-1:0] e = '1;
    for (int c = 0; c < 4; c++) e[(c*8)*W +: W] = 32'hFFFF_FFF8;
    inVld = 1'b1; inMode = 1'b0; inOp = 3'd0; inData = v;
    @(negedge clk); inVld = 1'b0;
    @(negedge clk);
    checkVec("R6 add wraps", outData, e);
    @(negedge clk);
  endtask

  task automatic tLaneLayout();
    // R1: a single marked lane lands at its own bit slice
    logic [VW-1:0] v = '0;
    logic [VW-1:0] e;
    v[5*W +: W] = 32'hA5A5_0005;
    v[16*W +: W] = 32'h0000_1000;
    e = v;
    e[16*W +: W] = 32'h0000_1000;
    e[0 +: W] = 32'h0;
    inVld = 1'b1; inMode = 1'b0; inOp = 3'd6; inData = v;
    @(negedge clk); inVld = 1'b0;
    @(negedge clk);
    e[0 +: W] = 32'hA5A5_0005;
    checkVec("R1 lane layout", outData, e);
    @(negedge clk);
  endtask

  task automatic tStream();
    logic [VW-1:0] vs [4];
    logic          ms [4];
    int            os [4];
    for (int k = 0; k < 4; k++) begin
      vs[k] = makeVec(40 + k);
      ms[k] = k[0];
      os[k] = (k * 3 + 1) % 8;
    end
    for (int k = 0; k < 6; k++) begin
      if (k >= 2) begin
        checkBit("R8 stream valid", outVld, 1'b1);
        checkVec("R8 stream order", outData, refVec(ms[k-2], os[k-2], vs[k-2]));
      end
      if (k < 4) begin
        inVld = 1'b1; inMode = ms[k]; inOp = 3'(os[k]); inData = vs[k];
      end else begin
        inVld = 1'b0;
      end
      @(negedge clk);
    end
    checkBit("R8 stream drained", outVld, 1'b0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nChecks++; nFails++;
    $display("FAIL watchdog: run did not finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    @(negedge clk);
    tReset();
    tChunkOps();
    tFinalOps();
    tAddWrap();
    tLaneLayout();
    tStream();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule